// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external controller read and write a small internal register file over a four-wire serial bus. The bus has an active-low chip select, a serial clock that idles high, a data input and a data output. The block runs entirely in a fast system clock domain. It brings the serial clock, chip select and data input through two-stage synchronisers. It then detects serial clock edges by comparing successive synchronised samples.

Every access begins with one command byte, which gives the direction and a register address. Data bytes follow, most significant byte first. The number of data bytes comes from the addressed register's width, which is fixed by an internal width rule. A write is committed only when its final data bit has arrived. A read captures the whole register at the end of the command byte. It then shifts that copy out on the data output.

Two addresses give read-only access to an external 8-bit status word. Reading the second of them also sends a one-cycle clear strobe to the interrupt logic. The data output comes with an enable, so that a pad driver can release the line whenever the block is not returning read data.

Top module: `spi_regslave`

## Requirements
- R1: The command byte is sent MSB first. Bit 7 is the direction (1 = write, 0 = read) and bits 4..0 are the register address. Bits 6..5 are ignored.
- R2: Register widths in bytes: addresses 4 and 5 are 1 byte wide. Every other address a is (a mod 5) + 1 bytes wide.
- R3: Write data is sampled on falling serial clock edges, bytes MSB first and bits MSB first. The value is committed when the last bit of the register's final byte arrives. Data bytes sent after that have no effect.
- R4: If chip select rises before the last bit of a write, the addressed register keeps its previous value.
- R5: For a read, the first data bit appears after the first rising serial clock edge that follows the command byte. Bytes and bits are sent MSB first, and bytes requested past the register width read as 0x00.
- R6: A read returns the register value as it was when the command byte completed, even if the source changes during the data phase.
- R7: Addresses 4 and 5 return status_i, and writes to them change nothing. A read of address 5 gives exactly one single-cycle status_clr pulse. Reads of address 4 and any write give none.
- R8: miso_oe is high only during the data phase of a read. It goes low within a few system clocks of chip select rising, and miso is low whenever miso_oe is low.
- R9: After reset all registers read as zero, and miso, miso_oe and status_clr are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for the miso pad driver |
| status_i | input | 8 | Status word from the interrupt logic |
| status_clr | output | 1 | One-cycle clear strobe to the interrupt logic |

## Verification
Directed frames cover each register width from one to five bytes. Readback tells a wrong byte order or a wrong width lookup apart from a good transfer. Overlong writes and reads probe what happens past the register boundary, and writes aborted at mid-byte and at one bit short separate early commit from correct staging. The status addresses are read while status_i changes in the middle of a frame, which exposes a design that fetches per byte instead of latching at command end. Random frames with random reserved command bits are then compared against a bench model of the register file.

// File: rtl/spi_regslave.sv
module spi_regslave #(
  parameter int         MAX_BYTES  = 5,
  parameter logic [4:0] STAT_ADDR  = 5'd4,
  parameter logic [4:0] RSTAT_ADDR = 5'd5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  output logic       miso,
  output logic       miso_oe,
  input  logic [7:0] status_i,
  output logic       status_clr
);
  localparam int DW    = 8 * MAX_BYTES;
  localparam int BCW   = $clog2(MAX_BYTES + 1);
  localparam int NREGS = 32;

  typedef enum logic [1:0] {S_CMD, S_WR, S_RD, S_DONE} st_t;

  function automatic logic [BCW-1:0] reg_bytes(input logic [4:0] a);
    if (a == STAT_ADDR || a == RSTAT_ADDR) return BCW'(1);
    return BCW'(32'(a) % MAX_BYTES + 1);
  endfunction

  logic [2:0] sclk_q;
  logic [1:0] cs_q, mosi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '1;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end

  wire sclk_fall = sclk_q[2] & ~sclk_q[1];
  wire sclk_rise = ~sclk_q[2] & sclk_q[1];
  wire cs_act    = ~cs_q[1];
  wire din       = mosi_q[1];

  logic [DW-1:0]  regs [NREGS];
  st_t            st;
  logic [2:0]     bitcnt;
  logic [BCW-1:0] bytecnt, nbytes;
  logic [4:0]     addr;
  logic [6:0]     cmd_sh;
  logic [DW-1:0]  wsh, osh;
  logic           armed;

  wire [7:0]     cmd_next = {cmd_sh, din};
  wire [4:0]     cmd_addr = cmd_next[4:0];
  wire [BCW-1:0] cmd_nb   = reg_bytes(cmd_addr);
  wire           last_bit = bitcnt == 3'd7;
  wire           last_byte = bytecnt == nbytes - BCW'(1);
  wire           commit   = cs_act && sclk_fall && st == S_WR && last_bit && last_byte;
  wire           is_stat  = addr == STAT_ADDR || addr == RSTAT_ADDR;
  wire           unused_bits = &{1'b0, cmd_next[6:5], wsh[DW-1]};

  logic [DW-1:0] rd_val;
  always_comb
    if (cmd_addr == STAT_ADDR || cmd_addr == RSTAT_ADDR) rd_val = DW'(status_i);
    else                                                 rd_val = regs[cmd_addr];

  wire [DW-1:0] rd_aligned = rd_val << (8 * (MAX_BYTES - 32'(cmd_nb)));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= S_CMD;
      bitcnt     <= '0;
      bytecnt    <= '0;
      nbytes     <= '0;
      addr       <= '0;
      cmd_sh     <= '0;
      wsh        <= '0;
      osh        <= '0;
      armed      <= 1'b0;
      status_clr <= 1'b0;
    end else begin
      status_clr <= 1'b0;
      if (!cs_act) begin
        st      <= S_CMD;
        bitcnt  <= '0;
        bytecnt <= '0;
        armed   <= 1'b0;
      end else begin
        if (sclk_fall) begin
          bitcnt <= bitcnt + 3'd1;
          unique case (st)
            S_CMD: begin
              cmd_sh <= cmd_next[6:0];
              if (last_bit) begin
                addr    <= cmd_addr;
                nbytes  <= cmd_nb;
                bytecnt <= '0;
                wsh     <= '0;
                if (cmd_next[7]) st <= S_WR;
                else begin
                  st         <= S_RD;
                  osh        <= rd_aligned;
                  status_clr <= cmd_addr == RSTAT_ADDR;
                end
              end
            end
            S_WR: begin
              wsh <= {wsh[DW-2:0], din};
              if (last_bit) begin
                bytecnt <= bytecnt + BCW'(1);
                if (last_byte) st <= S_DONE;
              end
            end
            default: ;
          endcase
        end
        if (sclk_rise && st == S_RD) begin
          if (armed) osh <= {osh[DW-2:0], 1'b0};
          armed <= 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (commit && !is_stat) begin
      regs[addr] <= {wsh[DW-2:0], din};
    end

  assign miso_oe = cs_act && st == S_RD && armed;
  assign miso    = miso_oe & osh[DW-1];

  // R8
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(sclk_rise));
  // R5
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && !sclk_rise) |=> (!miso_oe || $stable(miso)));
  // R7
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr |=> !status_clr);
  // R7
  clr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr |-> (st == S_RD && addr == RSTAT_ADDR));
  // R3
  wr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR) |-> (bytecnt < nbytes));
  // R3
  done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE) |-> ($past(st) == S_WR || $past(st) == S_DONE));
endmodule

// File: tb/spi_regslave_tb.sv
module spi_regslave_tb;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, mosi = 1'b0;
  logic [7:0] status_i = 8'h00;
  logic miso, miso_oe, status_clr;

  int n_chk = 0, n_bad = 0, clr_cnt = 0;
  logic [39:0] mdl [32];
  logic last_oe;

  always #2.5 clk = ~clk;

  spi_regslave u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .status_i(status_i), .status_clr(status_clr)
  );

  always @(posedge clk) if (status_clr) clr_cnt++;

  function automatic int wbytes(input int a);
    if (a == 4 || a == 5) return 1;
    return (a % 5) + 1;
  endfunction

  function automatic logic [39:0] wmask(input int nb);
    return (40'h1 << (8 * nb)) - 40'h1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso; sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
    end
  endtask

  task automatic frame(input logic [7:0] cmd, input int nb, input logic [39:0] wd, output logic [39:0] rd);
    logic [7:0] rx;
    rd = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    xbyte(cmd, rx);
    for (int k = 0; k < nb; k++) begin
      xbyte(wd[8*(nb-1-k) +: 8], rx);
      rd = {rd[31:0], rx};
    end
    repeat (HALF) @(negedge clk);
    last_oe = miso_oe;
    cs_n = 1'b1; mosi = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic abort_wr(input logic [7:0] cmd, input int nbits, input logic [39:0] wd);
    logic [7:0] rx;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    xbyte(cmd, rx);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); mosi = wd[39 - i];
      repeat (HALF) @(negedge clk); sclk = 1'b0;
      repeat (HALF) @(negedge clk); sclk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1; mosi = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [39:0] v);
    logic [39:0] d;
    frame(8'h80 | 8'(a), wbytes(a), v, d);
    if (a != 4 && a != 5) mdl[a] = v & wmask(wbytes(a));
  endtask

  task automatic rd_chk(input int a, input string req);
    logic [39:0] d, e;
    frame(8'(a), wbytes(a), '0, d);
    e = (a == 4 || a == 5) ? 40'(status_i) : mdl[a];
    chk(d == e, req, d, e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [39:0] d, e;
    int c0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 reset state
    chk(!miso_oe && !miso && !status_clr, "R9 outputs after reset", {miso_oe, miso, status_clr}, 0);
    rd_chk(9, "R9 register zero after reset");
    rd_chk(3, "R9 register zero after reset");

    // R2 R3 R5 one write/read per width
    foreach (mdl[a]) if (a < 4 || a == 9) begin
      wr(a, 40'hA1B2C3D4E5 ^ 40'(a));
      rd_chk(a, "R2 R3 R5 width readback");
    end

    // R5 bytes past width read as zero
    frame(8'h01, 3, '0, d);
    e = {mdl[1][15:0], 8'h00};
    chk(d == e, "R5 overlong read", d, e);
    chk(last_oe == 1'b1, "R8 oe during read data", 40'(last_oe), 1);
    repeat (2) @(negedge clk);
    chk(!miso_oe && !miso, "R8 oe released after cs", {miso_oe, miso}, 0);

    // R3 extra write bytes ignored
    frame(8'h80, 3, 40'h112233, d);
    chk(last_oe == 1'b0, "R8 no oe during write", 40'(last_oe), 0);
    mdl[0] = 40'h11;
    rd_chk(0, "R3 extra write bytes ignored");

    // R4 aborted writes
    wr(3, 40'h0C0FFEE0);
    abort_wr(8'h83, 20, 40'hFFFFFFFFFF);
    rd_chk(3, "R4 abort mid byte");
    abort_wr(8'h83, 31, 40'hFFFFFFFFFF);
    rd_chk(3, "R4 abort one bit short");
    abort_wr(8'h89, 39, 40'h123456789A);
    rd_chk(9, "R4 abort five byte one bit short");

    // R1 reserved command bits ignored
    frame(8'hE2, 3, 40'h5A6B7C, d);
    mdl[2] = 40'h5A6B7C;
    frame(8'h42, 3, '0, d);
    chk(d == mdl[2], "R1 reserved bits ignored", d, mdl[2]);

    // R7 status addresses
    status_i = 8'h3C;
    c0 = clr_cnt;
    rd_chk(4, "R7 status read");
    chk(clr_cnt == c0, "R7 no clear on plain status read", 40'(clr_cnt - c0), 0);
    rd_chk(5, "R7 clearing status read");
    chk(clr_cnt == c0 + 1, "R7 one clear pulse", 40'(clr_cnt - c0), 1);
    frame(8'h85, 1, 40'hFF, d);
    chk(clr_cnt == c0 + 1, "R7 write no clear", 40'(clr_cnt - c0), 1);
    rd_chk(5, "R7 status unaffected by write");

    // R6 coherence while status changes mid read
    status_i = 8'hA5;
    fork
      frame(8'h04, 1, '0, d);
      begin repeat (140) @(negedge clk); status_i = 8'h5A; end
    join
    chk(d == 40'hA5, "R6 coherent read", d, 40'hA5);

    // random frames
    for (int n = 0; n < 100; n++) begin
      int a;
      logic [7:0] cmd;
      logic [39:0] v;
      a = int'($urandom % 32);
      cmd = {1'b0, 2'($urandom), 5'(a)};
      status_i = 8'($urandom);
      if ($urandom % 2) begin
        v = {8'($urandom), 32'($urandom)} & wmask(wbytes(a));
        frame(cmd | 8'h80, wbytes(a), v, d);
        if (a != 4 && a != 5) mdl[a] = v;
      end else begin
        c0 = clr_cnt;
        frame(cmd, wbytes(a), '0, d);
        e = (a == 4 || a == 5) ? 40'(status_i) : mdl[a];
        chk(d == e, "R3 R5 random readback", d, e);
        chk(clr_cnt - c0 == ((a == 5) ? 1 : 0), "R7 random clear count", 40'(clr_cnt - c0), (a == 5) ? 1 : 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule